// File: doc/BRIEF.md
# MDIO Management Slave with Latched Interrupts

This block is the management end of a PHY. It runs on the management clock and decodes clause 22 serial frames arriving on the data line. It answers only frames whose PHY address field equals the 5-bit strapped address. The data line is split into an input, an output and an output enable, so the pad tristate sits outside the block. Behind the frame decoder is a small bank of 16-bit registers: read/write control registers, read-only identity and status placeholders, and an interrupt register.

The interrupt register holds a per-source enable byte in its upper half. Its lower half holds condition flags that latch single-cycle event pulses from the rest of the PHY. A management read of that register returns the flags and clears them. An event arriving on the same clock edge as the clearing read is kept. The interrupt pin is active while any flag is set together with its enable. A bit in the PHY control register selects whether the pin is active high or active low.

Top module: `mdio_intr_slave`

## Requirements
- R1: After reset, `mdio_oe` is 0 and `irq_o` is 1 (idle, active-low default). Register 0x00 reads 0x3100, register 0x04 reads 0x01E1 and register 0x1F reads 0x0000.
- R2: A frame is accepted in this order: at least 32 ones, then start bits 0,1, then a 2-bit opcode (10 = read, 01 = write), then the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits. All fields are MSB first. Every bit is sampled on the rising edge of `mdc`.
- R3: A frame whose PHY address differs from `phy_addr` is ignored: `mdio_oe` stays 0 and no register changes.
- R4: On a matching read, `mdio_oe` rises after the edge that samples the first turnaround bit, with `mdio_o` = 0. It stays high for exactly 17 cycles. Data bits 15..0 appear one per cycle, and each changes after a rising edge.
- R5: Registers 0x00, 0x04 and 0x1F store all 16 bits written and read them back.
- R6: Unimplemented addresses read as 0x0000, and writes to them have no effect.
- R7: Register 0x01 reads 0x7809, 0x02 reads 0x1234 and 0x03 reads 0x5A71. Writes to these registers are ignored.
- R8: A 1 on `evt_i[n]` at a rising edge sets condition bit n (register 0x1B bit n). The bit stays set until cleared by a read.
- R9: A read of 0x1B returns {enables, conditions} and clears every condition bit. The enable byte is unaffected.
- R10: An event sampled on the same edge as the last register-address bit of a read of 0x1B is not in the returned value, but stays latched afterwards.
- R11: The interrupt is active when (enables & conditions) is non-zero. With 0x1F bit 9 = 1, `irq_o` equals the active level; with bit 9 = 0, `irq_o` is its inverse.
- R12: Writes to 0x1B update only the enable byte (bits 15:8). The written bits 7:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Output enable for the data line |
| evt_i | input | 8 | Event pulses from the PHY, one per condition bit |
| irq_o | output | 1 | Interrupt pin, polarity set by 0x1F bit 9 |

## Verification
For a read, the header's last bit is sampled on edge k. The driven zero appears after edge k+1, and data bit 15-i appears after edge k+2+i. The bench drives one bit per falling edge, and at each falling edge it compares the enable and data against the frame position just finished. A write is committed on the edge that samples data bit 0, so it is only read back in a later frame. An event pulse is held across exactly one rising edge, and the interrupt pin is sampled at the following falling edge, one register later. The same-edge case lines the pulse up with the last header bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 5;
  localparam int EVT_W    = REG_W / 2;
  localparam int HDR_BITS = 2 + 2 * ADDR_W;
  localparam int POL_BIT  = 9;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [ADDR_W-1:0] RA_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] RA_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] RA_ID1  = 5'h02;
  localparam logic [ADDR_W-1:0] RA_ID2  = 5'h03;
  localparam logic [ADDR_W-1:0] RA_ADV  = 5'h04;
  localparam logic [ADDR_W-1:0] RA_IRQ  = 5'h1B;
  localparam logic [ADDR_W-1:0] RA_PCTL = 5'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_TA0, ST_TA1, ST_DATA
  } mdio_state_e;

  function automatic logic [1:0] hdr_op(input logic [HDR_BITS-1:0] h);
    return h[HDR_BITS-1 -: 2];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_phy(input logic [HDR_BITS-1:0] h);
    return h[2*ADDR_W-1 -: ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_reg(input logic [HDR_BITS-1:0] h);
    return h[ADDR_W-1:0];
  endfunction

  function automatic logic [EVT_W-1:0] cond_next(input logic [EVT_W-1:0] cond,
                                                 input logic [EVT_W-1:0] evt,
                                                 input logic clr);
    return (clr ? '0 : cond) | evt;
  endfunction

  function automatic logic irq_level(input logic [EVT_W-1:0] en,
                                     input logic [EVT_W-1:0] cond,
                                     input logic pol_high);
    logic act;
    act = |(en & cond);
    return pol_high ? act : ~act;
  endfunction
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_pkg::*;
#(
  parameter int PRE_ONES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              mdio_i,
  input  logic [REG_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_strobe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int PW = $clog2(PRE_ONES + 1);
  localparam logic [PW-1:0] PRE_MAX = PW'(PRE_ONES);
  localparam logic [3:0] HDR_LAST = 4'(HDR_BITS - 1);
  localparam logic [3:0] DATA_LAST = 4'(REG_W - 1);

  mdio_state_e          state_q;
  logic [PW-1:0]        pre_q;
  logic [3:0]           cnt_q;
  logic [HDR_BITS-1:0]  hdr_q;
  logic [HDR_BITS-1:0]  hdr_nxt;
  logic [REG_W-1:0]     sh_q;
  logic                 is_rd_q, is_wr_q;
  logic [ADDR_W-1:0]    reg_q;
  logic                 hdr_done, addr_hit, acc_rd, acc_wr;

  assign hdr_nxt  = {hdr_q[HDR_BITS-2:0], mdio_i};
  assign hdr_done = (state_q == ST_HDR) && (cnt_q == HDR_LAST);
  assign addr_hit = (hdr_phy(hdr_nxt) == phy_addr);
  assign acc_rd   = hdr_done && addr_hit && (hdr_op(hdr_nxt) == OP_RD);
  assign acc_wr   = hdr_done && addr_hit && (hdr_op(hdr_nxt) == OP_WR);

  assign rd_addr   = hdr_reg(hdr_nxt);
  assign rd_strobe = acc_rd;
  assign wr_addr   = reg_q;
  assign wr_data   = {sh_q[REG_W-2:0], mdio_i};
  assign wr_en     = (state_q == ST_DATA) && (cnt_q == DATA_LAST) && is_wr_q;

  assign mdio_oe = is_rd_q && ((state_q == ST_TA1) || (state_q == ST_DATA));
  assign mdio_o  = (state_q == ST_DATA) ? sh_q[REG_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      is_rd_q <= 1'b0;
      is_wr_q <= 1'b0;
      reg_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (mdio_i) begin
            if (pre_q != PRE_MAX) pre_q <= pre_q + 1'b1;
          end else begin
            pre_q <= '0;
            if (pre_q == PRE_MAX) state_q <= ST_START;
          end
        end
        ST_START: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr_q <= hdr_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_done) begin
            state_q <= ST_TA0;
            is_rd_q <= acc_rd;
            is_wr_q <= acc_wr;
            reg_q   <= hdr_reg(hdr_nxt);
            if (acc_rd) sh_q <= rd_data;
          end
        end
        ST_TA0: state_q <= ST_TA1;
        ST_TA1: begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: begin
          sh_q  <= {sh_q[REG_W-2:0], mdio_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DATA_LAST) begin
            state_q <= ST_IDLE;
            pre_q   <= '0;
            is_rd_q <= 1'b0;
            is_wr_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_irq.sv
module mdio_irq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr,
  input  logic             en_wr,
  input  logic [EVT_W-1:0] en_data,
  input  logic             pol_high,
  output logic [EVT_W-1:0] en_q,
  output logic [EVT_W-1:0] cond_q,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cond_q <= '0;
    end else begin
      cond_q <= cond_next(cond_q, evt_i, clr);
      if (en_wr) en_q <= en_data;
    end
  end

  assign irq_o = irq_level(en_q, cond_q, pol_high);
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_CTRL = 16'h3100,
  parameter logic [REG_W-1:0] RST_ADV  = 16'h01E1,
  parameter logic [REG_W-1:0] RST_PCTL = 16'h0000,
  parameter logic [REG_W-1:0] STAT_VAL = 16'h7809,
  parameter logic [REG_W-1:0] ID1_VAL  = 16'h1234,
  parameter logic [REG_W-1:0] ID2_VAL  = 16'h5A71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_strobe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [EVT_W-1:0]  irq_en,
  input  logic [EVT_W-1:0]  irq_cond,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_clr,
  output logic              irq_en_wr,
  output logic [EVT_W-1:0]  irq_en_data,
  output logic              pol_high
);
  localparam int NUM_RW   = 3;
  localparam int IDX_PCTL = 2;
  localparam logic [ADDR_W-1:0] RW_ADDR [NUM_RW] = '{RA_CTRL, RA_ADV, RA_PCTL};
  localparam logic [REG_W-1:0]  RW_RST  [NUM_RW] = '{RST_CTRL, RST_ADV, RST_PCTL};

  logic [REG_W-1:0] rw_q [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_q[g] <= RW_RST[g];
      else if (wr_en && (wr_addr == RW_ADDR[g])) rw_q[g] <= wr_data;
    end
  end

  assign pol_high    = rw_q[IDX_PCTL][POL_BIT];
  assign irq_clr     = rd_strobe && (rd_addr == RA_IRQ);
  assign irq_en_wr   = wr_en && (wr_addr == RA_IRQ);
  assign irq_en_data = wr_data[REG_W-1:EVT_W];

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_STAT: rd_data = STAT_VAL;
      RA_ID1:  rd_data = ID1_VAL;
      RA_ID2:  rd_data = ID2_VAL;
      RA_IRQ:  rd_data = {irq_en, irq_cond};
      default: rd_data = '0;
    endcase
    for (int i = 0; i < NUM_RW; i++) begin
      if (rd_addr == RW_ADDR[i]) rd_data = rw_q[i];
    end
  end
endmodule

// File: rtl/mdio_intr_slave.sv
module mdio_intr_slave
  import mdio_pkg::*;
#(
  parameter int PRE_ONES = 32
) (
  input  logic       mdc,
  input  logic       rst_n,
  input  logic [4:0] phy_addr,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic [7:0] evt_i,
  output logic       irq_o
);
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              rd_strobe, wr_en;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic [EVT_W-1:0]  irq_en, irq_cond, irq_en_data;
  logic              irq_clr, irq_en_wr, pol_high;

  mdio_frame_rx #(.PRE_ONES(PRE_ONES)) u_frame (
    .clk(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(mdio_i),
    .rd_data(rd_data), .rd_addr(rd_addr), .rd_strobe(rd_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regbank u_bank (
    .clk(mdc), .rst_n(rst_n), .rd_addr(rd_addr), .rd_strobe(rd_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_en(irq_en), .irq_cond(irq_cond), .rd_data(rd_data),
    .irq_clr(irq_clr), .irq_en_wr(irq_en_wr), .irq_en_data(irq_en_data),
    .pol_high(pol_high)
  );

  mdio_irq u_irq (
    .clk(mdc), .rst_n(rst_n), .evt_i(evt_i), .clr(irq_clr),
    .en_wr(irq_en_wr), .en_data(irq_en_data), .pol_high(pol_high),
    .en_q(irq_en), .cond_q(irq_cond), .irq_o(irq_o)
  );
endmodule

// File: rtl/mdio_intr_slave_chk.sv
module mdio_intr_slave_chk (
  input logic       mdc,
  input logic       rst_n,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       irq_o,
  input logic [7:0] evt_i,
  input logic [7:0] irq_en,
  input logic [7:0] irq_cond,
  input logic       irq_clr,
  input logic       pol_high
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else if (mdio_oe) oe_run <= oe_run + 1'b1;
    else oe_run <= '0;
  end

  assert_ta_zero_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  assert_oe_len_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    (!mdio_oe && oe_run != 0) |-> oe_run == 5'd17);

  assert_oe_bound_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> oe_run < 5'd17);

  assert_cond_hold_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    !irq_clr |=> ((irq_cond & $past(irq_cond)) == $past(irq_cond)));

  assert_evt_kept_R10: assert property (@(posedge mdc) disable iff (!rst_n)
    (evt_i != 8'd0) |=> ((irq_cond & $past(evt_i)) == $past(evt_i)));

  assert_clear_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    (irq_clr && evt_i == 8'd0) |=> irq_cond == 8'd0);

  assert_irq_pol_R11: assert property (@(posedge mdc) disable iff (!rst_n)
    irq_o == (pol_high ? (|(irq_en & irq_cond)) : !(|(irq_en & irq_cond))));
endmodule

bind mdio_intr_slave mdio_intr_slave_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .irq_o(irq_o), .evt_i(evt_i), .irq_en(irq_en), .irq_cond(irq_cond),
  .irq_clr(irq_clr), .pol_high(pol_high)
);

// File: tb/mdio_intr_slave_bench.sv
module mdio_intr_slave_bench;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'h0B;
  logic       mdio_i = 1'b1;
  logic       mdio_o, mdio_oe;
  logic [7:0] evt_i = 8'h00;
  logic       irq_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 mdc = ~mdc;

  mdio_intr_slave u_mdio_intr_slave (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full frame, bit p driven at a falling edge; outputs checked at the same edge.
  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input bit drive_exp, input bit evt_hdr,
                       input logic [7:0] evt_val, output logic [15:0] rd, output bit tim_ok);
    logic [63:0] fr;
    fr = {32'hFFFF_FFFF, 2'b01, op, pa, ra, (op == 2'b10) ? 2'b11 : 2'b10,
          (op == 2'b10) ? 16'hFFFF : wd};
    rd = 16'h0;
    tim_ok = 1'b1;
    for (int p = 0; p < 64; p++) begin
      @(negedge mdc);
      if (mdio_oe !== (drive_exp && p >= 47)) tim_ok = 1'b0;
      if (drive_exp && p == 47 && mdio_o !== 1'b0) tim_ok = 1'b0;
      if (p >= 48) rd[63-p] = mdio_o;
      mdio_i = fr[63-p];
      if (evt_hdr && p == 45) evt_i = evt_val;
      if (evt_hdr && p == 46) evt_i = 8'h00;
    end
    @(negedge mdc);
    if (mdio_oe !== 1'b0) tim_ok = 1'b0;
    mdio_i = 1'b1;
  endtask

  task automatic rd_reg(input logic [4:0] ra, output logic [15:0] v, output bit t);
    frame(2'b10, phy_addr, ra, 16'h0, 1'b1, 1'b0, 8'h0, v, t);
  endtask

  task automatic wr_reg(input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] v; bit t;
    frame(2'b01, phy_addr, ra, d, 1'b0, 1'b0, 8'h0, v, t);
    chk("R2 write frame leaves line released", {31'd0, t}, 32'd1);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge mdc); evt_i = v;
    @(negedge mdc); evt_i = 8'h00;
  endtask

  task automatic t_reset();
    logic [15:0] v; bit t;
    chk("R1 oe after reset", {31'd0, mdio_oe}, 32'd0);
    chk("R1 irq idle after reset", {31'd0, irq_o}, 32'd1);
    rd_reg(5'h00, v, t);
    chk("R1 reg 0x00 reset", {16'd0, v}, 32'h3100);
    chk("R4 read drive window", {31'd0, t}, 32'd1);
    rd_reg(5'h04, v, t); chk("R1 reg 0x04 reset", {16'd0, v}, 32'h01E1);
    rd_reg(5'h1F, v, t); chk("R1 reg 0x1F reset", {16'd0, v}, 32'h0000);
  endtask

  task automatic t_rw();
    logic [15:0] v; bit t;
    wr_reg(5'h04, 16'hA5C3);
    rd_reg(5'h04, v, t); chk("R5 reg 0x04 readback", {16'd0, v}, 32'hA5C3);
    chk("R4 timing on data read", {31'd0, t}, 32'd1);
    wr_reg(5'h00, 16'h8001);
    rd_reg(5'h00, v, t); chk("R5 R2 reg 0x00 MSB/LSB order", {16'd0, v}, 32'h8001);
  endtask

  task automatic t_filter();
    logic [15:0] v; bit t;
    frame(2'b01, 5'h0C, 5'h04, 16'hFFFF, 1'b0, 1'b0, 8'h0, v, t);
    chk("R3 foreign write no drive", {31'd0, t}, 32'd1);
    frame(2'b10, 5'h0A, 5'h04, 16'h0, 1'b0, 1'b0, 8'h0, v, t);
    chk("R3 foreign read no drive", {31'd0, t}, 32'd1);
    rd_reg(5'h04, v, t); chk("R3 reg unchanged by foreign write", {16'd0, v}, 32'hA5C3);
  endtask

  task automatic t_unimpl_ro();
    logic [15:0] v; bit t;
    wr_reg(5'h10, 16'hBEEF);
    rd_reg(5'h10, v, t); chk("R6 unimplemented reads zero", {16'd0, v}, 32'h0);
    rd_reg(5'h01, v, t); chk("R7 status value", {16'd0, v}, 32'h7809);
    wr_reg(5'h02, 16'h0000);
    rd_reg(5'h02, v, t); chk("R7 id1 read-only", {16'd0, v}, 32'h1234);
    rd_reg(5'h03, v, t); chk("R7 id2 value", {16'd0, v}, 32'h5A71);
  endtask

  task automatic t_irq();
    logic [15:0] v; bit t;
    pulse(8'h05);
    chk("R11 irq idle with no enables", {31'd0, irq_o}, 32'd1);
    rd_reg(5'h1B, v, t); chk("R8 R9 conditions latched", {16'd0, v}, 32'h0005);
    rd_reg(5'h1B, v, t); chk("R9 conditions cleared", {16'd0, v}, 32'h0000);
    wr_reg(5'h1B, 16'h03FF);
    rd_reg(5'h1B, v, t); chk("R12 only enables written", {16'd0, v}, 32'h0300);
    pulse(8'h04);
    chk("R11 disabled source no irq", {31'd0, irq_o}, 32'd1);
    pulse(8'h02);
    chk("R11 active-low asserted", {31'd0, irq_o}, 32'd0);
    wr_reg(5'h1F, 16'h0200);
    chk("R11 polarity high asserted", {31'd0, irq_o}, 32'd1);
    rd_reg(5'h1B, v, t); chk("R9 read returns enables and flags", {16'd0, v}, 32'h0306);
    chk("R11 R9 irq drops after clear", {31'd0, irq_o}, 32'd0);
    rd_reg(5'h1B, v, t); chk("R9 enable byte kept", {16'd0, v}, 32'h0300);
  endtask

  task automatic t_same_edge();
    logic [15:0] v; bit t;
    frame(2'b10, phy_addr, 5'h1B, 16'h0, 1'b1, 1'b1, 8'h80, v, t);
    chk("R10 event not in clearing read", {16'd0, v}, 32'h0300);
    rd_reg(5'h1B, v, t); chk("R10 event survives clear", {16'd0, v}, 32'h0380);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    t_reset();
    t_rw();
    t_filter();
    t_unimpl_ro();
    t_irq();
    t_same_edge();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule